// File: doc/BRIEF.md
# Carry Select Adder with Increment Converters

This block is a purely combinational adder of parameterised width (16 bits by default, 32 bits also supported). It takes two operands and a carry-in and returns the sum word together with a carry-out. Inside, the word is cut into 4-bit groups. The bottom group is a plain ripple adder fed by the external carry-in.

Every higher group has a single ripple adder that assumes its incoming carry is zero. An increment converter turns that 5-bit result (four sum bits plus the group carry) into the result for an incoming carry of one. A 2:1 selector, steered by the true carry leaving the group below, picks one of the two results. It picks the group's carry as well as its sum bits, and that carry steers the selector of the next group up.

The block holds no clock and no storage. A width that is not a multiple of 4 stops elaboration with an error.

Top module: `csel_adder`

## Requirements
- R1: With the default WIDTH of 16, {cout, sum} equals a + b + cin for every input combination, with cin taking the values 0 and 1.
- R2: With WIDTH set to 32 (or to 8, as another multiple of 4), {cout, sum} equals a + b + cin for every input combination.
- R3: Sum bits [3:0] and the carry leaving the bottom group equal the 5-bit value a[3:0] + b[3:0] + cin. This group is a ripple adder fed directly by cin.
- R4: In each higher group, the carry-in-one result equals the carry-in-zero result plus one, counted as a 5-bit value {carry, sum[3:0]}.
- R5: The carry leaving group g equals bit 4(g+1) of a[4g+3:0] + b[4g+3:0] + cin. A carry entering at cin therefore reaches cout through every group: all-ones plus zero with cin = 1 gives sum 0 and cout 1.
- R6: The outputs depend only on the present inputs. A change of the inputs shows up on sum and cout without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into the bottom group |
| sum | output | WIDTH | Sum word |
| cout | output | 1 | Carry out of the top group |

## Verification
Whenever the inputs change, the assertions check the total against an arithmetic reference, the bottom group's nibble result, each group's outgoing carry against a prefix sum of the operands, and the increment relation between each group's two candidate results. The bench can show things the assertions cannot. It runs an exhaustive sweep of an 8-bit build, targeted patterns (zeros, all ones, operands one apart, a carry that ripples through the full word) and random vectors at 16 and 32 bits. It also shows that outputs settle with no clock edge between a stimulus and its check.

// File: rtl/csel_pkg.sv
package csel_pkg;
  // Bits per select group; the increment converter spans GROUP_W + 1 bits.
  localparam int GROUP_W = 4;
endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] chain;
  assign chain[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic half;
    assign half        = x[i] ^ y[i];
    assign s[i]        = half ^ chain[i];
    assign chain[i+1]  = (x[i] & y[i]) | (half & chain[i]);
  end

  assign co = chain[W];
endmodule

// File: rtl/csel_inc5.sv
module csel_inc5
  import csel_pkg::*;
(
  input  logic [GROUP_W:0] v,
  output logic [GROUP_W:0] w
);
  // Bit i flips when every lower bit is set; the carry bit is set
  // when it was already set or the low field was all ones.
  assign w[0] = ~v[0];
  for (genvar i = 1; i < GROUP_W; i++) begin : g_bit
    assign w[i] = v[i] ^ (&v[i-1:0]);
  end
  assign w[GROUP_W] = v[GROUP_W] | (&v[GROUP_W-1:0]);
endmodule

// File: rtl/csel_group.sv
module csel_group
  import csel_pkg::*;
(
  input  logic [GROUP_W-1:0] x,
  input  logic [GROUP_W-1:0] y,
  input  logic               selIn,
  output logic [GROUP_W-1:0] s,
  output logic               co,
  output logic [GROUP_W:0]   zeroRes,
  output logic [GROUP_W:0]   oneRes
);
  logic [GROUP_W-1:0] zeroSum;
  logic               zeroCarry;

  csel_ripple #(.W(GROUP_W)) u_rca (
    .x (x),
    .y (y),
    .ci(1'b0),
    .s (zeroSum),
    .co(zeroCarry)
  );

  assign zeroRes = {zeroCarry, zeroSum};

  csel_inc5 u_inc (
    .v(zeroRes),
    .w(oneRes)
  );

  logic [GROUP_W:0] picked;
  assign picked = selIn ? oneRes : zeroRes;
  assign s      = picked[GROUP_W-1:0];
  assign co     = picked[GROUP_W];
endmodule

// File: rtl/csel_adder.sv
module csel_adder
  import csel_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NUM_GROUPS = WIDTH / GROUP_W;

  if ((WIDTH % GROUP_W) != 0 || WIDTH < GROUP_W) begin : g_bad_width
    $error("csel_adder: WIDTH must be a positive multiple of 4");
  end

  logic [NUM_GROUPS-1:0]            grpCarry;
  logic [NUM_GROUPS-1:0][GROUP_W:0] zeroRes;
  logic [NUM_GROUPS-1:0][GROUP_W:0] oneRes;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int LO = g * GROUP_W;
    if (g == 0) begin : g_base
      csel_ripple #(.W(GROUP_W)) u_base (
        .x (a[LO +: GROUP_W]),
        .y (b[LO +: GROUP_W]),
        .ci(cin),
        .s (sum[LO +: GROUP_W]),
        .co(grpCarry[g])
      );
      assign zeroRes[g] = '0;
      assign oneRes[g]  = '0;
    end else begin : g_sel
      csel_group u_sel (
        .x      (a[LO +: GROUP_W]),
        .y      (b[LO +: GROUP_W]),
        .selIn  (grpCarry[g-1]),
        .s      (sum[LO +: GROUP_W]),
        .co     (grpCarry[g]),
        .zeroRes(zeroRes[g]),
        .oneRes (oneRes[g])
      );
    end
  end

  assign cout = grpCarry[NUM_GROUPS-1];
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0]                a,
  input logic [WIDTH-1:0]                b,
  input logic                            cin,
  input logic [WIDTH-1:0]                sum,
  input logic                            cout,
  input logic [WIDTH/4-1:0]              grpCarry,
  input logic [WIDTH/4-1:0][4:0]         zeroRes,
  input logic [WIDTH/4-1:0][4:0]         oneRes
);
  localparam int NG = WIDTH / 4;

  logic [WIDTH:0] total;
  logic [4:0]     lowNib;
  assign total  = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
  assign lowNib = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, cin};

  always_comb begin
    p_total_r1: assert ({cout, sum} == total)
      else $error("R1/R2 total mismatch");
    p_low_group_r3: assert ({grpCarry[0], sum[3:0]} == lowNib)
      else $error("R3 bottom group mismatch");
  end

  for (genvar g = 0; g < NG; g++) begin : g_chk
    localparam int PW = 4 * (g + 1);
    logic [PW:0] pref;
    assign pref = {1'b0, a[PW-1:0]} + {1'b0, b[PW-1:0]} + {{PW{1'b0}}, cin};
    always_comb begin
      p_group_carry_r5: assert (grpCarry[g] == pref[PW])
        else $error("R5 group carry mismatch");
    end
    if (g > 0) begin : g_inc
      always_comb begin
        p_inc_relation_r4: assert (oneRes[g] == zeroRes[g] + 5'd1)
          else $error("R4 increment relation broken");
      end
    end
  end
endmodule

bind csel_adder csel_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a       (a),
  .b       (b),
  .cin     (cin),
  .sum     (sum),
  .cout    (cout),
  .grpCarry(grpCarry),
  .zeroRes (zeroRes),
  .oneRes  (oneRes)
);

// File: tb/csel_adder_bench.sv
`timescale 1ns/1ps
module csel_adder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [15:0] a16, b16, s16;  logic c16, o16;
  logic [31:0] a32, b32, s32;  logic c32, o32;
  logic [7:0]  a8,  b8,  s8;   logic c8,  o8;

  csel_adder #(.WIDTH(16)) u_csel_adder (
    .a(a16), .b(b16), .cin(c16), .sum(s16), .cout(o16));
  csel_adder #(.WIDTH(32)) u_csel_adder_w32 (
    .a(a32), .b(b32), .cin(c32), .sum(s32), .cout(o32));
  csel_adder #(.WIDTH(8)) u_csel_adder_w8 (
    .a(a8), .b(b8), .cin(c8), .sum(s8), .cout(o8));

  task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run16(input string req, input logic [15:0] x, input logic [15:0] y, input logic ci);
    logic [16:0] exp;
    a16 = x; b16 = y; c16 = ci;
    #1;
    exp = {1'b0, x} + {1'b0, y} + {16'd0, ci};
    check(req, {16'd0, o16, s16}, {16'd0, exp});
  endtask

  task automatic run32(input string req, input logic [31:0] x, input logic [31:0] y, input logic ci);
    logic [32:0] exp;
    a32 = x; b32 = y; c32 = ci;
    #1;
    exp = {1'b0, x} + {1'b0, y} + {32'd0, ci};
    check(req, {o32, s32}, exp);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    a16 = '0; b16 = '0; c16 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    a8  = '0; b8  = '0; c8  = 1'b0;
    #1;
    // R6: all-zero inputs give zero outputs with no clock edge needed
    check("R6 zero state", {16'd0, o16, s16}, 33'd0);
    check("R6 zero state w32", {o32, s32}, 33'd0);

    // R1 targeted patterns at default width
    run16("R1 zeros cin1", 16'h0000, 16'h0000, 1'b1);
    run16("R1 all ones", 16'hFFFF, 16'hFFFF, 1'b0);
    run16("R1 all ones cin1", 16'hFFFF, 16'hFFFF, 1'b1);
    run16("R1 differ by one", 16'h1233, 16'h1234, 1'b0);
    run16("R1 differ by one cin1", 16'h7FFF, 16'h8000, 1'b1);
    run16("R1 alternating", 16'hAAAA, 16'h5555, 1'b1);
    // R5: carry runs from cin through every group
    run16("R5 full ripple", 16'hFFFF, 16'h0000, 1'b1);
    run16("R5 carry into group 2", 16'h00F0, 16'h0010, 1'b0);
    // R3: bottom group nibble overflow feeds group 1
    run16("R3 bottom overflow", 16'h000F, 16'h0000, 1'b1);
    run16("R3 bottom max", 16'h000F, 16'h000F, 1'b1);
    // R4: group with carry-zero result 0x1E, then selected with carry in
    run16("R4 converter top value", 16'h00F1, 16'h00FF, 1'b0);
    run16("R4 converter wrap", 16'h0FF0, 16'h0010, 1'b0);

    // R2 targeted patterns at 32 bits
    run32("R2 zeros", 32'h0, 32'h0, 1'b0);
    run32("R2 all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    run32("R2 full ripple", 32'hFFFF_FFFF, 32'h0, 1'b1);
    run32("R2 differ by one", 32'h89AB_CDEE, 32'h89AB_CDEF, 1'b0);

    // R6: change inputs mid-cycle and sample before any clock edge
    @(posedge clk);
    #2;
    run16("R6 settle without edge", 16'h8001, 16'h7FFF, 1'b0);

    // R1 and R2 random vectors, both carry-in values
    for (int i = 0; i < 2000; i++) begin
      run16("R1 random", 16'($urandom), 16'($urandom), i[0]);
      run32("R2 random", $urandom, $urandom, i[1]);
    end

    // R2 exhaustive sweep of an 8-bit build
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int ci = 0; ci < 2; ci++) begin
          a8 = 8'(x); b8 = 8'(y); c8 = ci[0];
          #1;
          check("R2 sweep w8", {24'd0, o8, s8}, 33'(x + y + ci));
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule